// File: doc/BRIEF.md
# Asynchronous byte-lane memory controller

This block sits between a synchronous request port and an external 16-bit non-volatile memory that has an SRAM-style asynchronous interface. A request carries a direction, a 16-bit word address, write data and two byte enables. The controller turns it into one timed memory cycle. It drives the address, an active-low chip select, an active-low write strobe, an active-low output enable and two active-low byte strobes. It also drives the write data together with a separate drive-enable for the bidirectional pad. Read data is captured at the end of the access window and returned with a one-cycle valid pulse.

Every interface interval is given in picoseconds as a parameter and rounded up to whole periods of the system clock. With a 4 ns clock, the defaults give a write strobe of 5 cycles, a write recovery of 3 cycles, a read access window of 9 cycles, a bus release gap of 3 cycles and a select-to-select spacing of 9 cycles. A new command is accepted only when the controller is idle and the spacing from the previous select fall has run out. Burst transfers are not supported.

Top module: `async_mem_ctrl`

## Requirements
- R1: After reset all strobes (`mem_ce_n`, `mem_we_n`, `mem_oe_n`, `mem_lb_n`, `mem_ub_n`) are high, `mem_dout_en` and `rsp_valid` are low and `req_ready` is high.
- R2: A write drives chip select, write strobe and the enabled byte strobes low on the clock edge that accepts it. The write strobe stays low for the rounded-up maximum of the pulse, address-to-end and data-to-end minimums (5 cycles by default). Output enable stays high, and address, data and drive-enable stay stable for the whole pulse.
- R3: A read drives chip select, output enable and the enabled byte strobes low with the write strobe high for the rounded-up access time (9 cycles by default). `mem_din` is captured on the edge that ends the window. `rsp_valid` rises on that same edge, 9 edges after acceptance, and lasts exactly one cycle.
- R4: Byte-enable bit 0 drives `mem_lb_n` low and selects data bits 7:0. Bit 1 drives `mem_ub_n` low and selects bits 15:8. A write changes only the selected lanes of the addressed word.
- R5: In `rsp_rdata`, a lane whose byte enable was clear in the read request reads as zero.
- R6: Two successive falls of `mem_ce_n` are at least the rounded-up cycle time apart (9 cycles by default). `req_ready` is low from acceptance until that spacing has passed, so back-to-back commands are accepted exactly 9 cycles apart.
- R7: After the write strobe rises, address and write data stay driven for the rounded-up recovery time (3 cycles by default) before `mem_dout_en` falls.
- R8: `mem_dout_en` is never high while `mem_oe_n` is low. After a read, the data bus is not driven again until at least the rounded-up release time after output enable rises. With a read followed at once by a write, the two are accepted 13 cycles apart.
- R9: A write with both byte enables clear raises neither byte strobe and leaves the memory contents unchanged.
- R10: The full 16-bit request address reaches `mem_addr` unchanged, so the lowest and highest word addresses are distinct locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command request |
| req_ready | output | 1 | Controller idle and spacing elapsed; command accepted when both valid and ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low lane, bit 1 = high lane |
| rsp_valid | output | 1 | One-cycle read-data valid pulse |
| rsp_rdata | output | 16 | Read data, unrequested lanes zero |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low byte strobe, active low |
| mem_ub_n | output | 1 | High byte strobe, active low |
| mem_dout | output | 16 | Data toward the memory |
| mem_dout_en | output | 1 | Pad drive enable for `mem_dout` |
| mem_din | input | 16 | Data from the memory |

## Verification
The two events that can fall in the same cycle are the end of write recovery, which returns the controller to idle, and the expiry of the select-to-select spacing counter. With the default parameters both finish on the eighth edge after a write is accepted. The bench provokes this by holding a second write request ready behind the first and measuring the accept-to-accept distance. A behavioural memory model then judges, in nanoseconds, that the recovery hold and the select spacing were both honoured. A read followed at once by a write exercises the other overlap, bus release against the spacing count. That case is judged by the 13-cycle distance and by the model's contention and release checks.

// File: rtl/async_mem_ctrl.sv
`timescale 1ns/1ps
module async_mem_ctrl #(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int CLK_PS    = 4000,
  parameter int T_CYC_PS  = 35000,
  parameter int T_WP_PS   = 15000,
  parameter int T_AW_PS   = 18000,
  parameter int T_DW_PS   = 10000,
  parameter int T_REC_PS  = 12000,
  parameter int T_ACC_PS  = 35000,
  parameter int T_REL_PS  = 10000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic [DW-1:0] mem_dout,
  output logic          mem_dout_en,
  input  logic [DW-1:0] mem_din
);

  localparam int LW      = DW / 2;
  localparam int C_CYC   = (T_CYC_PS + CLK_PS - 1) / CLK_PS;
  localparam int C_WP    = (T_WP_PS  + CLK_PS - 1) / CLK_PS;
  localparam int C_AW    = (T_AW_PS  + CLK_PS - 1) / CLK_PS;
  localparam int C_DW    = (T_DW_PS  + CLK_PS - 1) / CLK_PS;
  localparam int C_REC   = (T_REC_PS + CLK_PS - 1) / CLK_PS;
  localparam int C_ACC   = (T_ACC_PS + CLK_PS - 1) / CLK_PS;
  localparam int C_REL   = (T_REL_PS + CLK_PS - 1) / CLK_PS;
  localparam int C_WMAX  = (C_WP > C_AW) ? ((C_WP > C_DW) ? C_WP : C_DW)
                                         : ((C_AW > C_DW) ? C_AW : C_DW);
  localparam int N_WR    = (C_WMAX < 1) ? 1 : C_WMAX;
  localparam int N_REC   = (C_REC  < 1) ? 1 : C_REC;
  localparam int N_ACC   = (C_ACC  < 1) ? 1 : C_ACC;
  localparam int N_REL   = (C_REL  < 1) ? 1 : C_REL;
  localparam int N_CYC   = (C_CYC  < 1) ? 1 : C_CYC;
  localparam int N_MAX   = (N_WR > N_ACC ? N_WR : N_ACC) > N_CYC
                           ? (N_WR > N_ACC ? N_WR : N_ACC) : N_CYC;
  localparam int CW      = $clog2(N_MAX + 2);

  typedef enum logic [2:0] {S_IDLE, S_WRITE, S_WREC, S_READ, S_REL} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] gap;
  logic          take;

  assign req_ready = (state == S_IDLE) && (gap == '0);
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      gap         <= '0;
      mem_addr    <= '0;
      mem_ce_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_oe_n    <= 1'b1;
      mem_lb_n    <= 1'b1;
      mem_ub_n    <= 1'b1;
      mem_dout    <= '0;
      mem_dout_en <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (gap != '0) gap <= gap - 1'b1;
      case (state)
        S_IDLE: if (take) begin
          mem_addr <= req_addr;
          mem_ce_n <= 1'b0;
          mem_lb_n <= ~req_be[0];
          mem_ub_n <= ~req_be[1];
          gap      <= CW'(N_CYC - 1);
          if (req_write) begin
            mem_we_n    <= 1'b0;
            mem_dout    <= req_wdata;
            mem_dout_en <= 1'b1;
            cnt         <= CW'(N_WR - 1);
            state       <= S_WRITE;
          end else begin
            mem_oe_n <= 1'b0;
            cnt      <= CW'(N_ACC - 1);
            state    <= S_READ;
          end
        end
        S_WRITE: if (cnt == '0) begin
          mem_we_n <= 1'b1;
          mem_ce_n <= 1'b1;
          mem_lb_n <= 1'b1;
          mem_ub_n <= 1'b1;
          cnt      <= CW'(N_REC - 1);
          state    <= S_WREC;
        end else cnt <= cnt - 1'b1;
        S_WREC: if (cnt == '0) begin
          mem_dout_en <= 1'b0;
          state       <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        S_READ: if (cnt == '0) begin
          rsp_rdata <= {mem_ub_n ? {LW{1'b0}} : mem_din[DW-1:LW],
                        mem_lb_n ? {LW{1'b0}} : mem_din[LW-1:0]};
          rsp_valid <= 1'b1;
          mem_ce_n  <= 1'b1;
          mem_oe_n  <= 1'b1;
          mem_lb_n  <= 1'b1;
          mem_ub_n  <= 1'b1;
          cnt       <= CW'(N_REL - 1);
          state     <= S_REL;
        end else cnt <= cnt - 1'b1;
        S_REL: if (cnt == '0) state <= S_IDLE;
               else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic          ce_q;
  logic [CW-1:0] since;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_q  <= 1'b1;
      since <= CW'(N_CYC);
    end else begin
      ce_q <= mem_ce_n;
      if (ce_q && !mem_ce_n) since <= CW'(1);
      else if (since < CW'(N_CYC)) since <= since + 1'b1;
    end
  end

  assert_oe_off_in_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n && mem_dout_en));

  assert_data_held_in_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_dout) && $stable(mem_addr)));

  assert_rsp_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_select_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_q && !mem_ce_n) |-> (since >= CW'(N_CYC)));

  assert_ready_deselected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dout_en));

  assert_addr_held_recovery_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dout_en && mem_we_n) |-> $stable(mem_addr));

  assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> mem_oe_n);

endmodule

// File: tb/async_mem_ctrl_test.sv
`timescale 1ns/1ps
module async_mem_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata, mem_addr, mem_dout;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dout_en;
  logic [15:0] mem_din = 16'hBAD0;

  int vectors = 0, errors = 0, cyc = 0, last_acc = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  async_mem_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din)
  );

  task automatic check(string req, int got, int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic viol(string req, string what);
    errors++;
    $display("FAIL %s: memory model %s at %0t", req, what, $realtime);
  endtask

  // behavioural memory model, evaluated every nanosecond between clock edges
  logic [15:0] store [int];
  logic        p_ce = 1, p_we = 1, p_oe = 1, p_lb = 1, p_ub = 1, p_den = 0;
  logic [15:0] p_addr = '0, w_addr, w_data;
  logic        w_lb, w_ub, in_wr = 0, in_rec = 0, have_ce = 0;
  realtime     t_ce = 0, t_wf = 0, t_wr = 0, t_oe = -100, t_acc = 0;

  function automatic logic [15:0] peek(logic [15:0] a);
    return store.exists(int'(a)) ? store[int'(a)] : 16'h0000;
  endfunction

  task automatic model_tick();
    realtime now = $realtime;
    logic [15:0] cur;
    if (!rst_n) return;
    if (p_ce && !mem_ce_n) begin
      if (have_ce && now - t_ce < 35.0) viol("R6", "select spacing under 35 ns");
      t_ce = now; have_ce = 1;
    end
    if ((p_ce && !mem_ce_n) || (p_oe && !mem_oe_n) || p_addr != mem_addr ||
        p_lb != mem_lb_n || p_ub != mem_ub_n) t_acc = now;
    if (p_we && !mem_we_n && !mem_ce_n) begin
      t_wf = now; w_addr = mem_addr; w_data = mem_dout;
      w_lb = mem_lb_n; w_ub = mem_ub_n; in_wr = 1;
    end
    if (in_wr && !mem_we_n) begin
      if (mem_addr != w_addr || mem_dout != w_data || !mem_dout_en || !mem_oe_n ||
          mem_ce_n || mem_lb_n != w_lb || mem_ub_n != w_ub)
        viol("R2", "signal change inside write pulse");
    end
    if (in_wr && mem_we_n) begin
      in_wr = 0;
      if (now - t_wf < 18.0) viol("R2", "write pulse under 18 ns");
      cur = peek(w_addr);
      if (!w_lb) cur[7:0]  = w_data[7:0];
      if (!w_ub) cur[15:8] = w_data[15:8];
      store[int'(w_addr)] = cur;
      t_wr = now; in_rec = 1;
    end
    if (in_rec && (mem_addr != w_addr || !mem_dout_en)) begin
      if (now - t_wr < 12.0) viol("R7", "recovery under 12 ns");
      in_rec = 0;
    end
    if (!p_oe && mem_oe_n) t_oe = now;
    if (!p_den && mem_dout_en && now - t_oe < 10.0) viol("R8", "bus driven within 10 ns of output release");
    if (mem_dout_en && !mem_oe_n) viol("R8", "bus contention");
    if (!mem_ce_n && !mem_oe_n && mem_we_n && now - t_acc >= 35.0) begin
      cur = peek(mem_addr);
      mem_din = {mem_ub_n ? 8'hEE : cur[15:8], mem_lb_n ? 8'hEE : cur[7:0]};
    end else mem_din = 16'hBAD0;
    p_ce = mem_ce_n; p_we = mem_we_n; p_oe = mem_oe_n; p_lb = mem_lb_n;
    p_ub = mem_ub_n; p_den = mem_dout_en; p_addr = mem_addr;
  endtask

  initial begin
    #0.5;
    forever begin #1; model_tick(); end
  end

  // issue one command; returns with inputs released just after the accept edge
  task automatic issue(bit wr, logic [15:0] a, logic [15:0] d, logic [1:0] be);
    req_write = wr; req_addr = a; req_wdata = d; req_be = be; req_valid = 1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 0;
    last_acc = cyc;
  endtask

  task automatic do_write(logic [15:0] a, logic [15:0] d, logic [1:0] be);
    issue(1, a, d, be);
  endtask

  task automatic do_read(string req, logic [15:0] a, logic [1:0] be, logic [15:0] exp);
    int n = 0;
    issue(0, a, 16'h0, be);
    while (n < 40) begin
      @(posedge clk); #1; n++;
      if (rsp_valid) break;
    end
    check({req, " read data"}, rsp_rdata, exp);
    check("R3 read latency", n, 9);
    @(posedge clk); #1;
    check("R3 valid single cycle", rsp_valid, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 strobes", {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'b11111);
    check("R1 drive and valid", {mem_dout_en, rsp_valid}, 0);
    check("R1 ready", req_ready, 1);
  endtask

  task automatic t_word();
    do_write(16'h0010, 16'h1234, 2'b11);
    check("R2 write strobes", {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'b00100);
    check("R6 ready low after accept", req_ready, 0);
    repeat (4) @(posedge clk); #1;
    check("R2 strobe still low at 4", mem_we_n, 0);
    @(posedge clk); #1;
    check("R2 strobe high at 5", mem_we_n, 1);
    repeat (2) @(posedge clk); #1;
    check("R7 data still driven", mem_dout_en, 1);
    @(posedge clk); #1;
    check("R7 drive released", mem_dout_en, 0);
    do_read("R3", 16'h0010, 2'b11, 16'h1234);
  endtask

  task automatic t_lanes();
    do_write(16'h0020, 16'h1111, 2'b11);
    do_write(16'h0020, 16'h22CC, 2'b01);
    do_read("R4 low lane", 16'h0020, 2'b11, 16'h11CC);
    do_write(16'h0020, 16'h77EE, 2'b10);
    do_read("R4 high lane", 16'h0020, 2'b11, 16'h77CC);
  endtask

  task automatic t_mask();
    do_read("R5 low only", 16'h0020, 2'b01, 16'h00CC);
    do_read("R5 high only", 16'h0020, 2'b10, 16'h7700);
  endtask

  task automatic t_back_to_back();
    int a0;
    do_write(16'h0100, 16'hA1A1, 2'b11);
    a0 = last_acc;
    do_write(16'h0101, 16'hB2B2, 2'b11);
    check("R6 write-write spacing", last_acc - a0, 9);
    do_read("R6", 16'h0100, 2'b11, 16'hA1A1);
    do_read("R6", 16'h0101, 2'b11, 16'hB2B2);
  endtask

  task automatic t_turnaround();
    int a0;
    issue(0, 16'h0100, 16'h0, 2'b11);
    a0 = last_acc;
    do_write(16'h0102, 16'hC3C3, 2'b11);
    check("R8 read-write spacing", last_acc - a0, 13);
    do_read("R8", 16'h0102, 2'b11, 16'hC3C3);
  endtask

  task automatic t_no_lanes();
    do_write(16'h0020, 16'hFFFF, 2'b00);
    check("R9 byte strobes idle", {mem_lb_n, mem_ub_n}, 2'b11);
    do_read("R9", 16'h0020, 2'b11, 16'h77CC);
  endtask

  task automatic t_extremes();
    do_write(16'hFFFF, 16'h5AA5, 2'b11);
    check("R10 address out", mem_addr, 16'hFFFF);
    do_write(16'h0000, 16'h0FF0, 2'b11);
    do_read("R10 top", 16'hFFFF, 2'b11, 16'h5AA5);
    do_read("R10 bottom", 16'h0000, 2'b11, 16'h0FF0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_word();
    t_lanes();
    t_mask();
    t_back_to_back();
    t_turnaround();
    t_no_lanes();
    t_extremes();
    repeat (20) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule